// File: doc/BRIEF.md
# Increment-on-Write Register Peripheral

A small memory-mapped peripheral behind an AXI4-Lite slave port. It holds four 32-bit registers, picked by word address. A processor writes a character into the low byte of register 0 and later reads back that character plus one. The increment is applied when the write is stored, with wrap at 8 bits. The upper three bytes of register 0 and all bytes of registers 1 to 3 behave as plain byte-strobed storage.

Each transfer is a single beat and only one transaction is open per direction. The write address and write data channels are taken in the same cycle. The slave raises both ready signals for exactly one cycle, and only when both valids are high and no write response is waiting. Back-pressure on the response channels is fully honoured. A write response stays up until the master takes it, and read data with its response stays up, unchanged, until the master takes it. While a write response is pending, new write requests are left waiting. While read data is pending, new read requests are left waiting.

Top module: `incr_reg_periph`

## Requirements
- R1: Four registers are selected by address bits [3:2], so index 0 is at 0x0, 1 at 0x4, 2 at 0x8 and 3 at 0xC. Address bits [1:0] have no effect on which register is written or read.
- R2: A write to register 0 with wstrb[0] set stores wdata[7:0] plus one, modulo 256, in bits [7:0]. For example, 0xFF is stored as 0x00.
- R3: On a write to register 0, bytes 1 to 3 are stored exactly as written, and each only when its own strobe bit is set. When wstrb[0] is clear, bits [7:0] keep their old value and are not incremented.
- R4: Registers 1 to 3 store every byte whose strobe is set, unmodified, and keep every byte whose strobe is clear.
- R5: awready and wready are always equal. Both go high for exactly one cycle, one cycle after awvalid and wvalid are both seen high while bvalid is low. The write takes effect on the cycle in which they are high. A single valid alone, or a pending response, holds them low.
- R6: bvalid goes high in the cycle after the write is taken and stays high until sampled with bready high. bresp is 2'b00.
- R7: arready pulses high for one cycle after arvalid is seen while rvalid is low. rvalid then rises with rresp 2'b00 and the addressed register in rdata. Both stay unchanged until sampled with rready high.
- R8: A synchronous active-low reset clears all four registers and drives awready, wready, bvalid, arready and rvalid low.
- R9: The increment is applied only at write time. Repeated reads of register 0 return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address taken (one-cycle pulse) |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte lane enables for the write |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data taken (one-cycle pulse) |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Master accepts the write response |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address taken (one-cycle pulse) |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Master accepts read data |

## Verification
The increment path is driven with ordinary characters, with 0xFF to show the wrap, and with full-strobe writes. It is also driven with lane-0-only writes and with upper-lane-only writes, which separate "incremented", "kept" and "written plain". Writes of the same kind to registers 1 to 3 show that only register 0 adds one. Addresses with nonzero low bits show that those bits do not change the selection. Handshake patterns cover:
- a lone awvalid;
- a new write presented while a response is held back;
- bready and rready held low for several cycles;
- back-to-back write-then-read pairs.

These tell a correct pulse-and-hold protocol apart from one that drops, repeats or accepts too early.

// File: rtl/incr_reg_pkg.sv
`timescale 1ns/1ps
package incr_reg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/incr_reg_wr_port.sv
`timescale 1ns/1ps
// Write-side handshake: address and data are taken together in one pulse.
module incr_reg_wr_port #(
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 2,
  parameter int BYTE_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  input  logic              wvalid,
  input  logic              bready,
  output logic              take_q,
  output logic              bvalid_q,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);
  logic both_valid;

  assign both_valid = awvalid && wvalid;
  // The shift drops the byte-offset bits; the cast keeps the register index.
  assign wr_idx     = IDX_W'(awaddr >> BYTE_LSB);
  assign wr_en      = take_q && both_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= !take_q && both_valid && !bvalid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else if (wr_en && !bvalid_q) begin
      bvalid_q <= 1'b1;
    end else if (bvalid_q && bready) begin
      bvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/incr_reg_rd_port.sv
`timescale 1ns/1ps
// Read-side handshake: one-cycle address pulse, registered data held until taken.
module incr_reg_rd_port #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2,
  parameter int BYTE_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] sel_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              arready_q,
  output logic              rvalid_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic rd_take;

  assign rd_idx  = IDX_W'(araddr >> BYTE_LSB);
  assign rd_take = arready_q && arvalid && !rvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arready_q <= 1'b0;
    end else begin
      arready_q <= !arready_q && arvalid && !rvalid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_take) begin
      rvalid_q <= 1'b1;
      rdata_q  <= sel_data;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/incr_reg_bank.sv
`timescale 1ns/1ps
// Register storage with byte strobes; one register bumps its low lane on write.
module incr_reg_bank
  import incr_reg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NREG     = 4,
  parameter int INCR_REG = 0,
  parameter int IDX_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/BYTE_W-1:0] wstrb,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int LANES = DATA_W / BYTE_W;

  logic [NREG-1:0][DATA_W-1:0] words;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] wval;
    logic              hit;

    if (r == INCR_REG) begin : g_incr
      assign wval = {wdata[DATA_W-1:BYTE_W], wdata[BYTE_W-1:0] + BYTE_W'(1)};
    end else begin : g_plain
      assign wval = wdata;
    end

    assign hit = wr_en && (wr_idx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        for (int b = 0; b < LANES; b++) begin
          if (wstrb[b]) word_q[b*BYTE_W +: BYTE_W] <= wval[b*BYTE_W +: BYTE_W];
        end
      end
    end

    assign words[r] = word_q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/incr_reg_periph.sv
`timescale 1ns/1ps
module incr_reg_periph
  import incr_reg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NREG     = 4,
  parameter int INCR_REG = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        awaddr,
  input  logic                     awvalid,
  output logic                     awready,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/BYTE_W-1:0] wstrb,
  input  logic                     wvalid,
  output logic                     wready,
  output logic [1:0]               bresp,
  output logic                     bvalid,
  input  logic                     bready,
  input  logic [ADDR_W-1:0]        araddr,
  input  logic                     arvalid,
  output logic                     arready,
  output logic [DATA_W-1:0]        rdata,
  output logic [1:0]               rresp,
  output logic                     rvalid,
  input  logic                     rready
);
  localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int BYTE_LSB = $clog2(DATA_W / BYTE_W);

  logic              take_q;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] sel_data;

  incr_reg_wr_port #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BYTE_LSB(BYTE_LSB)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid),
    .wvalid(wvalid), .bready(bready), .take_q(take_q), .bvalid_q(bvalid),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  incr_reg_bank #(
    .DATA_W(DATA_W), .NREG(NREG), .INCR_REG(INCR_REG), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wdata(wdata), .wstrb(wstrb), .rd_idx(rd_idx), .rd_data(sel_data)
  );

  incr_reg_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_LSB(BYTE_LSB)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .araddr(araddr), .arvalid(arvalid),
    .rready(rready), .sel_data(sel_data), .rd_idx(rd_idx),
    .arready_q(arready), .rvalid_q(rvalid), .rdata_q(rdata)
  );

  assign awready = take_q;
  assign wready  = take_q;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;
endmodule

// File: rtl/incr_reg_periph_chk.sv
`timescale 1ns/1ps
module incr_reg_periph_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              wvalid,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic              arvalid,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata
);
  p_aw_w_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    awready == wready);
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    awready |=> !awready);
  p_wr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awready) |-> $past(awvalid && wvalid && !bvalid));
  p_wr_no_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    awready |-> !bvalid);
  p_bset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (awready && awvalid && wvalid) |=> bvalid);
  p_bhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arready |=> !arready);
  p_rset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arready && arvalid && !rvalid) |=> rvalid);
  p_rhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> (!awready && !wready && !bvalid && !arready && !rvalid));
endmodule

bind incr_reg_periph incr_reg_periph_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .wvalid(wvalid),
  .awready(awready), .wready(wready), .bvalid(bvalid), .bready(bready),
  .arvalid(arvalid), .arready(arready), .rvalid(rvalid), .rready(rready),
  .rdata(rdata)
);

// File: tb/sim_incr_reg_periph.sv
`timescale 1ns/1ps
module sim_incr_reg_periph;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  awaddr, araddr;
  logic        awvalid, wvalid, bready, arvalid, rready;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  incr_reg_periph u0 (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid),
    .awready(awready), .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid),
    .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready), .rdata(rdata),
    .rresp(rresp), .rvalid(rvalid), .rready(rready)
  );

  // {write addr, read addr, strobes, write data, expected read}
  localparam logic [75:0] TBL [0:8] = '{
    {4'h0, 4'h0, 4'hF, 32'h11223341, 32'h11223342},  // R2 full write
    {4'h0, 4'h0, 4'h1, 32'hAAAAAAFF, 32'h11223300},  // R2 wrap
    {4'h0, 4'h0, 4'hE, 32'h55667788, 32'h55667700},  // R3 lane 0 kept
    {4'h0, 4'h0, 4'h2, 32'h000099FE, 32'h55669900},  // R3 one upper lane
    {4'h4, 4'h4, 4'hF, 32'hDEADBEEF, 32'hDEADBEEF},  // R4 no increment
    {4'h8, 4'hA, 4'h3, 32'h12345678, 32'h00005678},  // R4 partial, R1 low bits
    {4'hF, 4'hC, 4'hF, 32'hCAFEF00D, 32'hCAFEF00D},  // R1 low bits on write
    {4'h1, 4'h2, 4'h1, 32'h0000007F, 32'h55669980},  // R1 + R2
    {4'h4, 4'h4, 4'h8, 32'h01000000, 32'h01ADBEEF}   // R4 top lane
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d,
                          input logic [3:0] s, input int bdly);
    int guard;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!awready && guard < 20);
    chk("R5 both readies together", {31'b0, awready & wready}, 32'd1);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    chk("R5 ready one cycle", {31'b0, awready}, 32'd0);
    chk("R6 bvalid after take", {31'b0, bvalid}, 32'd1);
    chk("R6 bresp okay", {30'b0, bresp}, 32'd0);
    for (int i = 0; i < bdly; i++) begin
      @(negedge clk);
      chk("R6 bvalid held", {31'b0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk("R6 bvalid dropped", {31'b0, bvalid}, 32'd0);
  endtask

  task automatic do_read(input logic [3:0] a, input int rdly, output logic [31:0] d);
    int guard;
    logic [31:0] first;
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!arready && guard < 20);
    chk("R7 arready seen", {31'b0, arready}, 32'd1);
    @(negedge clk);
    arvalid = 1'b0;
    chk("R7 rvalid after take", {31'b0, rvalid}, 32'd1);
    chk("R7 arready one cycle", {31'b0, arready}, 32'd0);
    chk("R7 rresp okay", {30'b0, rresp}, 32'd0);
    first = rdata;
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk("R7 rvalid held", {31'b0, rvalid}, 32'd1);
      chk("R7 rdata stable", rdata, first);
    end
    d = rdata;
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk("R7 rvalid dropped", {31'b0, rvalid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] rd, rd2;
    rst_n = 1'b0; awaddr = '0; araddr = '0; awvalid = 0; wvalid = 0;
    wdata = '0; wstrb = '0; bready = 0; arvalid = 0; rready = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset readies/valids",
        {27'b0, awready, wready, bvalid, arready, rvalid}, 32'd0);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      do_read(4'(r * 4), 0, rd);
      chk("R8 register clear after reset", rd, 32'h0);
    end

    // Vector walk: each row is a write followed by a read.
    for (int i = 0; i < 9; i++) begin
      do_write(TBL[i][75:72], TBL[i][63:32], TBL[i][67:64], i % 3);
      do_read(TBL[i][71:68], (i % 2) * 3, rd);
      chk($sformatf("R1/R2/R3/R4 vector %0d", i), rd, TBL[i][31:0]);
    end

    // R9: reading register 0 does not bump it.
    do_read(4'h0, 0, rd);
    do_read(4'h0, 2, rd2);
    chk("R9 repeated read stable", rd2, rd);
    chk("R9 value unchanged by reads", rd2, 32'h55669980);

    // R5: a lone write-address valid must not be taken.
    @(negedge clk);
    awaddr = 4'hC; wdata = 32'h0BADF00D; wstrb = 4'hF; awvalid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 lone awvalid not taken", {31'b0, awready}, 32'd0);
    end
    awvalid = 1'b0;
    do_read(4'hC, 0, rd);
    chk("R5 lone awvalid no write", rd, 32'hCAFEF00D);

    // R5: a new write waits while a response is pending.
    @(negedge clk);
    awaddr = 4'h4; wdata = 32'h00000042; wstrb = 4'h1; awvalid = 1; wvalid = 1;
    do begin @(negedge clk); end while (!awready);
    @(negedge clk);
    awaddr = 4'h8; wdata = 32'hFFFFFFFF; wstrb = 4'hF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 no take while response pending", {31'b0, awready}, 32'd0);
      chk("R6 bvalid held with bready low", {31'b0, bvalid}, 32'd1);
    end
    awvalid = 0; wvalid = 0;
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    do_read(4'h8, 0, rd);
    chk("R5 blocked write had no effect", rd, 32'h00005678);
    do_read(4'h4, 0, rd);
    chk("R4 lane 0 plain on register 1", rd, 32'h01ADBE42);

    // R8: reset in the middle of operation.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 reset mid-run outputs",
        {27'b0, awready, wready, bvalid, arready, rvalid}, 32'd0);
    rst_n = 1'b1;
    do_read(4'h0, 0, rd);
    chk("R8 register 0 cleared", rd, 32'h0);
    do_read(4'h4, 0, rd);
    chk("R8 register 1 cleared", rd, 32'h0);

    finish_up();
  end
endmodule